// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is the shared timebase for a set of capture and compare channels. An up-counter advances once every 2^k system clocks. The exponent k comes from a 3-bit select field, so the divide ratio runs from 1 to 128. A run bit starts and stops the count. An optional mode returns the counter to zero when it equals an external compare value, which comes from compare channel 7.

When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears the flag by writing a one to it. In fast-clear mode, software can also clear it just by reading the count. An interrupt output is raised while the flag is set and its enable bit is on. Software uses a small word-wide register port. The whole count comes back in a single read, so no partial-word tearing can occur.

Top module: `pfr_timer`

## Requirements
- R1: After synchronous reset the count, both control registers, the overflow flag, the read data and the interrupt output are all zero.
- R2: Register select 0 returns the zero-extended count and ignores writes. Select 1 is control A: run at bit 7, fast-clear at bit 4. Select 2 is control B: interrupt enable at bit 7, match-reset enable at bit 3, prescale select at bits 2:0. Select 3 is status: overflow flag at bit 7. Unused bits read 0. Read data is registered: it appears on the clock edge that samples the read strobe and holds the value that was present before that edge.
- R3: The count changes only while run is 1. Clearing run holds the current value.
- R4: With select code p, the count N clocks after the edge that set run is N >> p. The first advance therefore comes 2^p clocks after run is set.
- R5: Clearing run restarts the prescaler. After run is set again, the next advance again comes a full 2^p clocks later.
- R6: An advance from the all-ones count to zero sets the overflow flag on that same edge.
- R7: Writing status with bit 7 = 1 clears the flag. Writing bit 7 = 0 has no effect. Reading the count while fast-clear is 0 has no effect on the flag.
- R8: When fast-clear is 1, a read of the count clears the flag.
- R9: If a flag-setting wrap falls on the same edge as a clear (by write or by fast read), the flag ends up set.
- R10: With match-reset enabled, an advance while the count equals the compare input loads zero. This does not set the flag, even when the compare value is all ones.
- R11: The interrupt output equals the overflow flag AND the interrupt enable, on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| cmp7_val_i | input | CNT_W | Compare value from channel 7 |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A counter wrap and a flag clear can land on the same clock edge. The bench provokes this by timing the clear exactly: it starts the counter at divide-by-1, counts off the clocks until the edge on which the count reaches all ones and wraps, and issues the clear on that edge. This is done once with a write-one clear and once with a fast-clear count read. Both cases pass only if the status read that follows shows the flag set. The count returned by the colliding read is also checked, against the all-ones value it held just before the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SEL_COUNT  = 2'd0;
  localparam logic [1:0] SEL_CTRL_A = 2'd1;
  localparam logic [1:0] SEL_CTRL_B = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  localparam int RUN_BIT  = 7;
  localparam int FAST_BIT = 4;
  localparam int IE_BIT   = 7;
  localparam int MRST_BIT = 3;
  localparam int FLAG_BIT = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  localparam int DIV_W = (1 << PSEL_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(psel_i));
    end
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)        pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
    else            pre_q <= '0;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && psel_i != '0) ##1 (psel_i == $past(psel_i)) |-> !tick_o);

  // R5
  stop_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             match_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic match_hit;

  assign match_hit = match_en_i && (cnt_o == cmp_i);
  assign wrap_o    = tick_i && !match_hit && (&cnt_o);

  always_ff @(posedge clk) begin
    if (rst)              cnt_o <= '0;
    else if (tick_i) begin
      if (match_hit)      cnt_o <= '0;
      else                cnt_o <= cnt_o + 1'b1;
    end
  end

  // R10
  match_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && match_en_i && cnt_o == cmp_i) |=> (cnt_o == '0));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  always_comb begin
    if (set_i)      flag_nxt_o = 1'b1;
    else if (clr_i) flag_nxt_o = 1'b0;
    else            flag_nxt_o = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_nxt_o;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pfr_timer.sv
module pfr_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  cmp7_val_i,
  output logic              irq_o
);
  import tmr_pkg::*;

  logic              run_q, fast_q, ie_q, mrst_q;
  logic [PSEL_W-1:0] psel_q;
  logic              tick, wrap, flag, flag_nxt;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cnt_ext, ctrl_a_rd, ctrl_b_rd, status_rd;
  logic              wr_a, wr_b, clr_w1c, clr_fast, ie_nxt;

  assign wr_a     = bus_wr_i && (bus_sel_i == SEL_CTRL_A);
  assign wr_b     = bus_wr_i && (bus_sel_i == SEL_CTRL_B);
  assign clr_w1c  = bus_wr_i && (bus_sel_i == SEL_STATUS) && bus_wdata_i[FLAG_BIT];
  assign clr_fast = bus_rd_i && (bus_sel_i == SEL_COUNT) && fast_q;
  assign ie_nxt   = wr_b ? bus_wdata_i[IE_BIT] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      fast_q <= 1'b0;
      ie_q   <= 1'b0;
      mrst_q <= 1'b0;
      psel_q <= '0;
    end else begin
      if (wr_a) begin
        run_q  <= bus_wdata_i[RUN_BIT];
        fast_q <= bus_wdata_i[FAST_BIT];
      end
      if (wr_b) begin
        ie_q   <= bus_wdata_i[IE_BIT];
        mrst_q <= bus_wdata_i[MRST_BIT];
        psel_q <= bus_wdata_i[PSEL_W-1:0];
      end
    end
  end

  tmr_prescaler #(.PSEL_W(PSEL_W)) presc_i (
    .clk(clk), .rst(rst), .run_i(run_q), .psel_i(psel_q), .tick_o(tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick_i(tick), .match_en_i(mrst_q),
    .cmp_i(cmp7_val_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  tmr_ovf_flag flag_i (
    .clk(clk), .rst(rst), .set_i(wrap), .clr_i(clr_w1c || clr_fast),
    .flag_o(flag), .flag_nxt_o(flag_nxt)
  );

  always_comb begin
    cnt_ext              = '0;
    cnt_ext[CNT_W-1:0]   = cnt;
    ctrl_a_rd            = '0;
    ctrl_a_rd[RUN_BIT]   = run_q;
    ctrl_a_rd[FAST_BIT]  = fast_q;
    ctrl_b_rd            = '0;
    ctrl_b_rd[IE_BIT]    = ie_q;
    ctrl_b_rd[MRST_BIT]  = mrst_q;
    ctrl_b_rd[PSEL_W-1:0] = psel_q;
    status_rd            = '0;
    status_rd[FLAG_BIT]  = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      irq_o <= flag_nxt && ie_nxt;
      if (bus_rd_i) begin
        case (bus_sel_i)
          SEL_COUNT:  bus_rdata_o <= cnt_ext;
          SEL_CTRL_A: bus_rdata_o <= ctrl_a_rd;
          SEL_CTRL_B: bus_rdata_o <= ctrl_b_rd;
          default:    bus_rdata_o <= status_rd;
        endcase
      end
    end
  end

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(cnt));

  // R11
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag && ie_q));

  // R2
  count_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_sel_i == SEL_COUNT) |=> (bus_rdata_o[CNT_W-1:0] == $past(cnt)));
endmodule

// File: tb/pfr_timer_tb.sv
module pfr_timer_tb_top;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        bus_sel = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [CNT_W-1:0]  cmp7 = '0;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pfr_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PSEL_W(3)) dut_i (
    .clk(clk), .rst(rst), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cmp7_val_i(cmp7), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    bus_sel = sel; bus_wdata = DATA_W'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int data);
    bus_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  initial begin
    int v;
    do_reset();
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd1, v); chk("R1 ctrl_a", v, 0);
    rd(2'd2, v); chk("R1 ctrl_b", v, 0);
    rd(2'd3, v); chk("R1 status", v, 0);

    // R4 prescale sweep: count N clocks after run = N >> p
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 4; k++) begin
        int w;
        case (k)
          0: w = (1 << p) - 1;
          1: w = (1 << p);
          2: w = (3 << p) + p;
          default: w = (7 << p) - 1;
        endcase
        do_reset();
        wr(2'd2, p);
        wr(2'd1, 'h80);
        repeat (w) @(negedge clk);
        rd(2'd0, v);
        chk($sformatf("R4 p=%0d w=%0d", p, w), v, w >> p);
      end
    end

    // R3 stop holds; R2 count writes ignored, readback masks
    do_reset();
    wr(2'd1, 'h80);
    repeat (20) @(negedge clk);
    wr(2'd1, 'h00);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R3 held", v, 21);
    wr(2'd0, 'h55);
    rd(2'd0, v); chk("R2 count write ignored", v, 21);
    wr(2'd2, 'hFF);
    rd(2'd2, v); chk("R2 ctrl_b readback", v, 'h8F);
    wr(2'd1, 'hFF);
    rd(2'd1, v); chk("R2 ctrl_a readback", v, 'h90);

    // R5 prescaler restart after stop
    do_reset();
    wr(2'd2, 2);
    wr(2'd1, 'h80);
    repeat (5) @(negedge clk);
    wr(2'd1, 'h00);
    wr(2'd1, 'h80);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R5 no early tick", v, 1);
    rd(2'd0, v); chk("R5 tick after full period", v, 2);

    // R6 / R11 / R7 overflow, interrupt and write-one clear
    do_reset();
    wr(2'd2, 'h80);
    wr(2'd1, 'h80);
    repeat (255) @(negedge clk);
    chk("R11 irq before wrap", int'(irq), 0);
    @(negedge clk);
    chk("R11 irq at wrap", int'(irq), 1);
    rd(2'd3, v); chk("R6 flag set", v, 'h80);
    wr(2'd3, 'h00);
    rd(2'd3, v); chk("R7 write zero no effect", v, 'h80);
    rd(2'd0, v);
    rd(2'd3, v); chk("R7 normal read no clear", v, 'h80);
    wr(2'd3, 'h80);
    rd(2'd3, v); chk("R7 w1c clears", v, 0);
    chk("R11 irq cleared", int'(irq), 0);

    // R8 fast clear by count read
    do_reset();
    wr(2'd1, 'h90);
    repeat (256) @(negedge clk);
    rd(2'd3, v); chk("R8 flag set", v, 'h80);
    rd(2'd0, v);
    rd(2'd3, v); chk("R8 fast clear", v, 0);

    // R9 set wins over same-edge clear
    do_reset();
    wr(2'd1, 'h80);
    repeat (255) @(negedge clk);
    wr(2'd3, 'h80);
    rd(2'd3, v); chk("R9 set beats w1c", v, 'h80);
    do_reset();
    wr(2'd1, 'h90);
    repeat (255) @(negedge clk);
    rd(2'd0, v); chk("R9 colliding read count", v, 255);
    rd(2'd3, v); chk("R9 set beats fast clear", v, 'h80);

    // R10 match reset
    do_reset();
    cmp7 = 8'd10;
    wr(2'd2, 'h08);
    wr(2'd1, 'h80);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R10 at match", v, 10);
    rd(2'd0, v); chk("R10 zero after match", v, 0);
    rd(2'd0, v); chk("R10 resumes", v, 1);
    do_reset();
    cmp7 = 8'hFF;
    wr(2'd2, 'h88);
    wr(2'd1, 'h80);
    repeat (260) @(negedge clk);
    rd(2'd3, v); chk("R10 no flag on match wrap", v, 0);
    chk("R10 no irq", int'(irq), 0);
    rd(2'd0, v); chk("R10 count after match wrap", v, 5);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      wait (done);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule